// File: doc/BRIEF.md
# Serial Clock-Generator Configuration Receiver

This block is a two-wire serial slave that only accepts writes. It runs on the system clock. It oversamples the SCL and SDA lines through a short synchronizer and detects start and stop conditions and SCL edges. It then follows a fixed message: an address byte, a command byte, a count byte, and up to the counted number of data bytes. The command and count bytes are acknowledged but not stored. Data bytes always fill the control registers starting at register 0 and moving upward. No index can be chosen.

The result is a parallel image of six 8-bit control bytes. The clock outputs use these bytes as per-output enables and as mode selects. Four mode fields are also brought out as separate pins. The block never stretches SCL and never returns data. Its only output onto the bus is a pull-down enable for an open-drain SDA driver.

Top module: `cfgs_top`

## Requirements
- R1: After reset the image holds byte0=0xB6, byte1=0x3F, byte2=0xE0, byte3=0x7E, byte4=0x00, byte5=0x00. Byte k occupies image bits 8k+7..8k. Output-enable bits reset to 1; mode and reserved bits reset to 0.
- R2: The address byte 0xD2 is acknowledged. Any other address byte is not acknowledged, and every later byte up to the next start or stop is ignored and not acknowledged. The registers do not change.
- R3: The byte after the address is a command byte. It is acknowledged whatever its value and is never stored.
- R4: A count byte of 0 or of more than 32 is not acknowledged, and the data that follows is ignored and not acknowledged.
- R5: Bits arrive MSB first. The first data byte after the count goes to byte0, the next to byte1, and so on.
- R6: A stop after any complete data byte ends the write. Bytes already written keep their new values and the rest keep their old values.
- R7: Data bytes within the count but beyond the sixth register are acknowledged and discarded.
- R8: Data bytes beyond the count are not acknowledged and not stored.
- R9: spread_en_o mirrors byte0 bit 3, mem_fast_o mirrors byte3 bit 0, vclk_fast_o mirrors byte4 bit 7, and ssoc_mode_o mirrors byte5 bits 6:5.
- R10: A start in mid-message restarts at the address phase. A stop returns the block to idle.
- R11: The SDA pull-down is asserted only during the ninth clock of an accepted byte. It is released after the falling SCL edge that ends that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (wired level) |
| sda_pull_o | output | 1 | Enable for the open-drain SDA pull-down |
| cfg_image_o | output | 48 | Control bytes 0..5, byte k in bits 8k+7..8k |
| spread_en_o | output | 1 | Spread-spectrum enable |
| mem_fast_o | output | 1 | Memory-clock fast mode |
| vclk_fast_o | output | 1 | Video clock mode (1 = spread 66 MHz) |
| ssoc_mode_o | output | 2 | Spread / overclock mode select |

## Verification
The bench drives the bus the way a host does and checks the wired SDA level at each ninth clock and the register image after each message. It targets the corner cases that a wrong design gets visibly wrong:
- A foreign address: a design that fails here acknowledges it or latches the data that follows.
- A count byte of 0 or 33: a design that fails here writes anyway.
- A message longer than the register bank: a design that fails here wraps and overwrites byte0.
- Extra bytes past the count: a design that fails here still acknowledges them.
- A repeated start partway through a message: a design that fails here treats the new address as data.
- A stop partway through a write: a design that fails here loses or corrupts bytes already written.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA,
        PH_SKIP
    } phase_e;

    // Reset value of each control byte: enables high, modes/reserved low
    function automatic logic [7:0] rst_byte(input int idx);
        case (idx)
            0:       rst_byte = 8'hB6;
            1:       rst_byte = 8'h3F;
            2:       rst_byte = 8'hE0;
            3:       rst_byte = 8'h7E;
            default: rst_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgs_sampler.sv
module cfgs_sampler #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [SYNC_LEN-1:0] scl_sh_q, scl_sh_d, sda_sh_q, sda_sh_d;
    logic scl_old_q, scl_old_d, sda_old_q, sda_old_d;
    logic scl_now, sda_now;

    always_comb begin
        scl_sh_d  = {scl_sh_q[SYNC_LEN-2:0], scl_i};
        sda_sh_d  = {sda_sh_q[SYNC_LEN-2:0], sda_i};
        scl_now   = scl_sh_q[SYNC_LEN-1];
        sda_now   = sda_sh_q[SYNC_LEN-1];
        scl_old_d = scl_now;
        sda_old_d = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q  <= '1;
            sda_sh_q  <= '1;
            scl_old_q <= 1'b1;
            sda_old_q <= 1'b1;
        end else begin
            scl_sh_q  <= scl_sh_d;
            sda_sh_q  <= sda_sh_d;
            scl_old_q <= scl_old_d;
            sda_old_q <= sda_old_d;
        end
    end

    assign sda_lvl_o  = sda_now;
    assign scl_rise_o = scl_now & ~scl_old_q;
    assign scl_fall_o = ~scl_now & scl_old_q;
    assign start_o    = scl_now & scl_old_q & sda_old_q & ~sda_now;
    assign stop_o     = scl_now & scl_old_q & ~sda_old_q & sda_now;

    // R10: a start and a stop are never flagged in the same cycle
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

endmodule

// File: rtl/cfgs_proto.sv
module cfgs_proto
    import cfgs_pkg::*;
#(
    parameter logic [7:0] ADDR_BYTE = 8'hD2,
    parameter int         NREG      = 6,
    parameter int         MAX_COUNT = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sda_lvl_i,
    input  logic                      scl_rise_i,
    input  logic                      scl_fall_i,
    input  logic                      start_i,
    input  logic                      stop_i,
    output logic                      sda_pull_o,
    output logic                      wr_en_o,
    output logic [$clog2(NREG)-1:0]   wr_idx_o,
    output logic [7:0]                wr_data_o
);
    localparam int CNT_W  = $clog2(MAX_COUNT + 1);
    localparam int RIDX_W = $clog2(NREG);
    localparam logic [CNT_W-1:0] NREG_L = CNT_W'(NREG);
    localparam logic [7:0]       MAXC_L = 8'(MAX_COUNT);

    typedef struct packed {
        phase_e           ph;
        logic [3:0]       bits;
        logic             ackph;
        logic             pull;
        logic [7:0]       sh;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] idx;
    } eng_t;

    eng_t q, d;
    logic wr_en;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (stop_i) begin
            d.ph    = PH_IDLE;
            d.bits  = '0;
            d.ackph = 1'b0;
            d.pull  = 1'b0;
        end else if (start_i) begin
            d.ph    = PH_ADDR;
            d.bits  = '0;
            d.ackph = 1'b0;
            d.pull  = 1'b0;
            d.rem   = '0;
            d.idx   = '0;
        end else if (q.ph != PH_IDLE && q.ph != PH_SKIP) begin
            if (scl_rise_i && !q.ackph && q.bits < 4'd8) begin
                d.sh   = {q.sh[6:0], sda_lvl_i};
                d.bits = q.bits + 4'd1;
            end
            if (scl_fall_i) begin
                if (q.ackph) begin
                    d.ackph = 1'b0;
                    d.pull  = 1'b0;
                    d.bits  = '0;
                end else if (q.bits == 4'd8) begin
                    d.ackph = 1'b1;
                    case (q.ph)
                        PH_ADDR: begin
                            if (q.sh == ADDR_BYTE) begin
                                d.pull = 1'b1;
                                d.ph   = PH_CMD;
                            end else begin
                                d.ph = PH_SKIP;
                            end
                        end
                        PH_CMD: begin
                            d.pull = 1'b1;
                            d.ph   = PH_CNT;
                        end
                        PH_CNT: begin
                            if (q.sh != 8'd0 && q.sh <= MAXC_L) begin
                                d.pull = 1'b1;
                                d.rem  = q.sh[CNT_W-1:0];
                                d.idx  = '0;
                                d.ph   = PH_DATA;
                            end else begin
                                d.ph = PH_SKIP;
                            end
                        end
                        PH_DATA: begin
                            if (q.rem != '0) begin
                                d.pull = 1'b1;
                                d.rem  = q.rem - 1'b1;
                                d.idx  = q.idx + 1'b1;
                                wr_en  = (q.idx < NREG_L);
                            end else begin
                                d.ph = PH_SKIP;
                            end
                        end
                        default: d.ph = PH_SKIP;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, bits: '0, ackph: 1'b0, pull: 1'b0,
                   sh: '0, rem: '0, idx: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign wr_en_o    = wr_en;
    assign wr_idx_o   = q.idx[RIDX_W-1:0];
    assign wr_data_o  = q.sh;

    // R2
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_SKIP) |-> !q.pull);
    // R11
    pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pull) |-> $past(scl_fall_i));
    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.ph == PH_IDLE && !q.pull));
    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DATA) |-> (q.rem <= CNT_W'(MAX_COUNT)));
    // R5
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.bits <= 4'd8);

endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank
    import cfgs_pkg::*;
#(
    parameter int NREG = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [$clog2(NREG)-1:0] wr_idx_i,
    input  logic [7:0]              wr_data_i,
    output logic [NREG*8-1:0]       image_o
);
    localparam int RIDX_W = $clog2(NREG);

    for (genvar g = 0; g < NREG; g++) begin : g_byte
        logic [7:0] b_q, b_d;

        always_comb begin
            b_d = b_q;
            if (wr_en_i && wr_idx_i == RIDX_W'(g)) b_d = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) b_q <= rst_byte(g);
            else        b_q <= b_d;
        end

        assign image_o[g*8 +: 8] = b_q;
    end

    // R7
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_idx_i < RIDX_W'(NREG)));

endmodule

// File: rtl/cfgs_top.sv
module cfgs_top #(
    parameter logic [7:0] ADDR_BYTE = 8'hD2,
    parameter int         NREG      = 6,
    parameter int         MAX_COUNT = 32,
    parameter int         SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [NREG*8-1:0] cfg_image_o,
    output logic              spread_en_o,
    output logic              mem_fast_o,
    output logic              vclk_fast_o,
    output logic [1:0]        ssoc_mode_o
);
    localparam int RIDX_W = $clog2(NREG);

    logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [7:0] wr_data;

    cfgs_sampler #(.SYNC_LEN(SYNC_LEN)) u_samp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl_o(sda_lvl), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    cfgs_proto #(.ADDR_BYTE(ADDR_BYTE), .NREG(NREG), .MAX_COUNT(MAX_COUNT)) u_proto (
        .clk(clk), .rst_n(rst_n), .sda_lvl_i(sda_lvl),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_ev), .stop_i(stop_ev),
        .sda_pull_o(sda_pull_o), .wr_en_o(wr_en),
        .wr_idx_o(wr_idx), .wr_data_o(wr_data)
    );

    cfgs_regbank #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en),
        .wr_idx_i(wr_idx), .wr_data_i(wr_data), .image_o(cfg_image_o)
    );

    assign spread_en_o = cfg_image_o[0*8 + 3];
    assign mem_fast_o  = cfg_image_o[3*8 + 0];
    assign vclk_fast_o = cfg_image_o[4*8 + 7];
    assign ssoc_mode_o = cfg_image_o[5*8 + 5 +: 2];

    // R6
    image_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(cfg_image_o));

endmodule

// File: tb/cfgs_top_tb.sv
module cfgs_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 40;
    localparam int QTR  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_sda = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [47:0] image;
    logic spread_en, mem_fast, vclk_fast;
    logic [1:0] ssoc_mode;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_b [6];

    assign sda_line = host_sda & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgs_top u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .cfg_image_o(image),
        .spread_en_o(spread_en), .mem_fast_o(mem_fast),
        .vclk_fast_o(vclk_fast), .ssoc_mode_o(ssoc_mode)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_flat();
        logic [47:0] f;
        for (int k = 0; k < 6; k++) f[k*8 +: 8] = exp_b[k];
        return f;
    endfunction

    task automatic chk_image(input string req);
        chk(image === exp_flat(), req, 64'(image), 64'(exp_flat()));
    endtask

    task automatic bus_start();
        wait_cyc(QTR); host_sda = 1'b1;
        wait_cyc(QTR); scl = 1'b1;
        wait_cyc(QTR); host_sda = 1'b0;
        wait_cyc(QTR); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_cyc(QTR); host_sda = 1'b0;
        wait_cyc(QTR); scl = 1'b1;
        wait_cyc(QTR); host_sda = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wait_cyc(QTR); host_sda = b[i];
            wait_cyc(QTR); scl = 1'b1;
            wait_cyc(HALF); scl = 1'b0;
        end
        wait_cyc(QTR); host_sda = 1'b1;
        wait_cyc(QTR); scl = 1'b1;
        wait_cyc(QTR); acked = (sda_line == 1'b0);
        wait_cyc(QTR); scl = 1'b0;
        wait_cyc(QTR);
        // R11: pull released after the ninth falling edge
        chk(sda_pull == 1'b0, "R11", 64'(sda_pull), 64'(0));
    endtask

    task automatic send_exp(input logic [7:0] b, input logic exp_ack, input string req);
        logic a;
        bus_byte(b, a);
        chk(a == exp_ack, req, 64'(a), 64'(exp_ack));
    endtask

    task automatic t_reset();
        exp_b[0] = 8'hB6; exp_b[1] = 8'h3F; exp_b[2] = 8'hE0;
        exp_b[3] = 8'h7E; exp_b[4] = 8'h00; exp_b[5] = 8'h00;
        chk_image("R1");
        chk(sda_pull == 1'b0, "R1", 64'(sda_pull), 64'(0));
        chk({spread_en, mem_fast, vclk_fast, ssoc_mode} == 5'b0, "R9",
            64'({spread_en, mem_fast, vclk_fast, ssoc_mode}), 64'(0));
    endtask

    task automatic t_full();
        logic [7:0] v [6];
        v[0] = 8'h08; v[1] = 8'h15; v[2] = 8'hA0;
        v[3] = 8'h01; v[4] = 8'h80; v[5] = 8'h60;
        bus_start();
        send_exp(8'hD2, 1'b1, "R2");
        send_exp(8'h5A, 1'b1, "R3");
        send_exp(8'h06, 1'b1, "R5");
        for (int k = 0; k < 6; k++) begin
            send_exp(v[k], 1'b1, "R5");
            exp_b[k] = v[k];
        end
        bus_stop();
        chk_image("R5");
        chk({spread_en, mem_fast, vclk_fast, ssoc_mode} == 5'b11111, "R9",
            64'({spread_en, mem_fast, vclk_fast, ssoc_mode}), 64'h1F);
    endtask

    task automatic t_bad_addr();
        bus_start();
        send_exp(8'hD0, 1'b0, "R2");
        send_exp(8'h00, 1'b0, "R2");
        send_exp(8'h01, 1'b0, "R2");
        send_exp(8'hFF, 1'b0, "R2");
        bus_stop();
        chk_image("R2");
    endtask

    task automatic t_bad_count();
        bus_start();
        send_exp(8'hD2, 1'b1, "R4");
        send_exp(8'h00, 1'b1, "R3");
        send_exp(8'h00, 1'b0, "R4");
        send_exp(8'h77, 1'b0, "R4");
        bus_stop();
        chk_image("R4");
        bus_start();
        send_exp(8'hD2, 1'b1, "R4");
        send_exp(8'h00, 1'b1, "R3");
        send_exp(8'h21, 1'b0, "R4");
        send_exp(8'h44, 1'b0, "R4");
        bus_stop();
        chk_image("R4");
    endtask

    task automatic t_partial();
        bus_start();
        send_exp(8'hD2, 1'b1, "R6");
        send_exp(8'h00, 1'b1, "R6");
        send_exp(8'h04, 1'b1, "R6");
        send_exp(8'hC3, 1'b1, "R6"); exp_b[0] = 8'hC3;
        send_exp(8'h3C, 1'b1, "R6"); exp_b[1] = 8'h3C;
        bus_stop();
        chk_image("R6");
    endtask

    task automatic t_long();
        bus_start();
        send_exp(8'hD2, 1'b1, "R7");
        send_exp(8'h00, 1'b1, "R7");
        send_exp(8'h20, 1'b1, "R7");
        for (int k = 0; k < 8; k++) begin
            send_exp(8'(8'h90 + k), 1'b1, "R7");
            if (k < 6) exp_b[k] = 8'(8'h90 + k);
        end
        bus_stop();
        chk_image("R7");
    endtask

    task automatic t_over();
        bus_start();
        send_exp(8'hD2, 1'b1, "R8");
        send_exp(8'h00, 1'b1, "R8");
        send_exp(8'h01, 1'b1, "R8");
        send_exp(8'h81, 1'b1, "R8"); exp_b[0] = 8'h81;
        send_exp(8'h42, 1'b0, "R8");
        bus_stop();
        chk_image("R8");
    endtask

    task automatic t_restart();
        bus_start();
        send_exp(8'hD2, 1'b1, "R10");
        send_exp(8'h00, 1'b1, "R10");
        bus_start();
        send_exp(8'hD2, 1'b1, "R10");
        send_exp(8'h00, 1'b1, "R10");
        send_exp(8'h01, 1'b1, "R10");
        send_exp(8'h55, 1'b1, "R10"); exp_b[0] = 8'h55;
        bus_stop();
        chk_image("R10");
        chk(spread_en == 1'b0, "R9", 64'(spread_en), 64'(0));
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_full();
        t_bad_addr();
        t_bad_count();
        t_partial();
        t_long();
        t_over();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule